// File: doc/BRIEF.md
# Configuration Request Intercept Channel

This block sits between the configuration-space handler of a PCIe endpoint and the application logic. Each time the handler strobes a received configuration read or write request for one cycle, the block packs the decoded header fields and any write payload into a fixed 72-bit word. It then offers that word to the application on a valid/ready channel. The word stays in place until the application acknowledges it with a one-cycle ready pulse, so the application can put off the request while it does its own housekeeping.

While a word is waiting, the block raises a stall toward the configuration handler and takes no new request. The control is a two-state machine. In state ST_IDLE nothing is held. The transition CAPTURE goes from ST_IDLE to ST_HOLD when the request strobe is seen, and it loads the packed word. In state ST_HOLD, valid and stall are high. The transition RELEASE goes from ST_HOLD back to ST_IDLE when ready is seen. Any other input leaves the state as it is: a strobe in ST_HOLD is dropped, and a ready in ST_IDLE is dropped.

Top module: `cfg_intercept_chan`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) clears icpt_valid_o and stall_o and sets icpt_word_o to all zeros.
- R2: In the captured word, bit 0 is the poisoned flag, bits 4:1 are the first-dword byte enables, bits 9:5 are zero and bits 12:10 are the physical function number.
- R3: In the captured word, bits 23:13 are the virtual function number, bit 24 is the virtual-function-valid flag, bits 35:26 are the dword register address and bits 71:68 are zero.
- R4: Bit 25 of the captured word is the write flag. For a write, bits 67:36 carry the payload in little-endian order: req_wdata_i[7:0], the first byte received, lands in bits 43:36, and each following byte lands eight bits higher.
- R5: For a read (write flag low), bits 67:36 of the captured word are zero.
- R6: A strobe seen in ST_IDLE (CAPTURE) makes icpt_valid_o high from the next clock edge on.
- R7: A ready seen while icpt_valid_o is high (RELEASE) makes icpt_valid_o low after that edge. If ready is already high when valid first rises, valid is high for exactly one cycle.
- R8: While icpt_valid_o is high and no ready has been seen, icpt_word_o does not change. After a release, the last word stays on icpt_word_o.
- R9: stall_o is high exactly while a word is held. A strobe that arrives while stall_o is high is ignored: the word does not change and no extra request appears after the release.
- R10: A ready pulse while icpt_valid_o is low is ignored: valid stays low, and the next request is still held until its own ready arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_strobe_i | input | 1 | One-cycle strobe marking a received configuration request |
| req_poison_i | input | 1 | Poisoned flag from the request header |
| req_byte_en_i | input | 4 | First-dword byte enables |
| req_pf_i | input | 3 | Physical function number |
| req_vf_i | input | 11 | Virtual function number |
| req_vf_ok_i | input | 1 | Virtual function number is valid |
| req_is_write_i | input | 1 | High for a configuration write, low for a read |
| req_dw_addr_i | input | 10 | Dword register address |
| req_wdata_i | input | 32 | Write payload, first received byte in bits 7:0 |
| stall_o | output | 1 | Held word not yet acknowledged; the handler must wait |
| icpt_valid_o | output | 1 | Captured word is being offered |
| icpt_ready_i | input | 1 | One-cycle acknowledge from the application |
| icpt_word_o | output | 72 | Packed request word |

## Verification
Valid, stall and the word all come from registers, so each result appears one clock edge after the input that causes it. A strobe at edge k shows up as valid, stall and a new word just after edge k, and a ready at edge k clears valid and stall just after edge k. The bench changes inputs one time unit after a rising edge. It advances a reference model at the next rising edge and compares all outputs one time unit after that edge, so each comparison falls in the cycle the requirement sets. The word is checked field group by field group (R2 to R5) in every cycle, including the cycles after a release in which it must stay unchanged.

// File: rtl/cfg_icpt_pkg.sv
package cfg_icpt_pkg;

    // Field widths of the decoded configuration header
    localparam int BE_W   = 4;
    localparam int PF_W   = 3;
    localparam int VF_W   = 11;
    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;
    localparam int BYTE_W = 8;
    localparam int LANES  = DATA_W / BYTE_W;

    // Bit positions of the packed word (decoded by the application)
    localparam int POS_POISON = 0;
    localparam int POS_BE     = POS_POISON + 1;
    localparam int POS_RSV_LO = POS_BE + BE_W;
    localparam int RSV_LO_W   = 5;
    localparam int POS_PF     = POS_RSV_LO + RSV_LO_W;
    localparam int POS_VF     = POS_PF + PF_W;
    localparam int POS_VF_OK  = POS_VF + VF_W;
    localparam int POS_WR     = POS_VF_OK + 1;
    localparam int POS_ADDR   = POS_WR + 1;
    localparam int POS_DATA   = POS_ADDR + ADDR_W;
    localparam int POS_RSV_HI = POS_DATA + DATA_W;
    localparam int RSV_HI_W   = 4;
    localparam int WORD_W     = POS_RSV_HI + RSV_HI_W;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } icpt_state_e;

    typedef struct packed {
        logic              poison;
        logic [BE_W-1:0]   byte_en;
        logic [PF_W-1:0]   pf;
        logic [VF_W-1:0]   vf;
        logic              vf_ok;
        logic              is_write;
        logic [ADDR_W-1:0] dw_addr;
        logic [DATA_W-1:0] wdata;
    } cfg_hdr_t;

endpackage

// File: rtl/cfg_icpt_pack.sv
module cfg_icpt_pack
    import cfg_icpt_pkg::*;
(
    input  cfg_hdr_t           hdr_i,
    output logic [WORD_W-1:0]  word_o
);

    logic [DATA_W-1:0] payload;

    // Little-endian lane placement: the first received byte takes the lowest lane
    for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
        assign payload[lane*BYTE_W +: BYTE_W] =
            hdr_i.is_write ? hdr_i.wdata[lane*BYTE_W +: BYTE_W] : '0;
    end

    always_comb begin
        word_o                        = '0;
        word_o[POS_POISON]            = hdr_i.poison;
        word_o[POS_BE +: BE_W]        = hdr_i.byte_en;
        word_o[POS_PF +: PF_W]        = hdr_i.pf;
        word_o[POS_VF +: VF_W]        = hdr_i.vf;
        word_o[POS_VF_OK]             = hdr_i.vf_ok;
        word_o[POS_WR]                = hdr_i.is_write;
        word_o[POS_ADDR +: ADDR_W]    = hdr_i.dw_addr;
        word_o[POS_DATA +: DATA_W]    = payload;
    end

endmodule

// File: rtl/cfg_icpt_fsm.sv
module cfg_icpt_fsm
    import cfg_icpt_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic ready_i,
    output logic capture_o,
    output logic valid_o,
    output logic stall_o
);

    icpt_state_e state_q;
    icpt_state_e state_d;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: CAPTURE and RELEASE
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (strobe_i) state_d = ST_HOLD;
            ST_HOLD: if (ready_i)  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        capture_o = 1'b0;
        valid_o   = 1'b0;
        stall_o   = 1'b0;
        unique case (state_q)
            ST_IDLE: capture_o = strobe_i;
            ST_HOLD: begin
                valid_o = 1'b1;
                stall_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/cfg_icpt_hold.sv
module cfg_icpt_hold #(
    parameter int W = 72
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (load_i) begin
            q_o <= d_i;
        end
    end

endmodule

// File: rtl/cfg_intercept_chan.sv
module cfg_intercept_chan
    import cfg_icpt_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_strobe_i,
    input  logic              req_poison_i,
    input  logic [BE_W-1:0]   req_byte_en_i,
    input  logic [PF_W-1:0]   req_pf_i,
    input  logic [VF_W-1:0]   req_vf_i,
    input  logic              req_vf_ok_i,
    input  logic              req_is_write_i,
    input  logic [ADDR_W-1:0] req_dw_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              stall_o,
    output logic              icpt_valid_o,
    input  logic              icpt_ready_i,
    output logic [WORD_W-1:0] icpt_word_o
);

    cfg_hdr_t          hdr;
    logic [WORD_W-1:0] packed_word;
    logic              capture;

    always_comb begin
        hdr.poison   = req_poison_i;
        hdr.byte_en  = req_byte_en_i;
        hdr.pf       = req_pf_i;
        hdr.vf       = req_vf_i;
        hdr.vf_ok    = req_vf_ok_i;
        hdr.is_write = req_is_write_i;
        hdr.dw_addr  = req_dw_addr_i;
        hdr.wdata    = req_wdata_i;
    end

    cfg_icpt_pack pack_i (
        .hdr_i  (hdr),
        .word_o (packed_word)
    );

    cfg_icpt_fsm fsm_i (
        .clk       (clk),
        .rst       (rst),
        .strobe_i  (req_strobe_i),
        .ready_i   (icpt_ready_i),
        .capture_o (capture),
        .valid_o   (icpt_valid_o),
        .stall_o   (stall_o)
    );

    cfg_icpt_hold #(.W(WORD_W)) hold_i (
        .clk    (clk),
        .rst    (rst),
        .load_i (capture),
        .d_i    (packed_word),
        .q_o    (icpt_word_o)
    );

endmodule

// File: rtl/cfg_icpt_chk.sv
module cfg_icpt_chk
    import cfg_icpt_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_strobe_i,
    input logic              stall_o,
    input logic              icpt_valid_o,
    input logic              icpt_ready_i,
    input logic [WORD_W-1:0] icpt_word_o
);

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!icpt_valid_o && !stall_o && icpt_word_o == '0));

    // R6
    capture_raises_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (req_strobe_i && !icpt_valid_o) |=> icpt_valid_o);

    // R7
    release_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
        (icpt_valid_o && icpt_ready_i) |=> !icpt_valid_o);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (icpt_valid_o && !icpt_ready_i) |=> (icpt_valid_o && $stable(icpt_word_o)));

    // R8
    idle_keeps_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!icpt_valid_o && !req_strobe_i) |=> $stable(icpt_word_o));

    // R9
    stall_tracks_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall_o == icpt_valid_o);

    // R10
    idle_ready_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!icpt_valid_o && !req_strobe_i && icpt_ready_i) |=> !icpt_valid_o);

    // R5
    read_payload_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (icpt_valid_o && !icpt_word_o[POS_WR]) |-> icpt_word_o[POS_DATA +: DATA_W] == '0);

    // R2
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        icpt_valid_o |-> (icpt_word_o[POS_RSV_LO +: RSV_LO_W] == '0
                          && icpt_word_o[POS_RSV_HI +: RSV_HI_W] == '0));

endmodule

bind cfg_intercept_chan cfg_icpt_chk chk_i (
    .clk          (clk),
    .rst          (rst),
    .req_strobe_i (req_strobe_i),
    .stall_o      (stall_o),
    .icpt_valid_o (icpt_valid_o),
    .icpt_ready_i (icpt_ready_i),
    .icpt_word_o  (icpt_word_o)
);

// File: tb/cfg_intercept_chan_tb_top.sv
`timescale 1ns/1ps
module cfg_intercept_chan_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_strobe_i;
    logic        req_poison_i;
    logic [3:0]  req_byte_en_i;
    logic [2:0]  req_pf_i;
    logic [10:0] req_vf_i;
    logic        req_vf_ok_i;
    logic        req_is_write_i;
    logic [9:0]  req_dw_addr_i;
    logic [31:0] req_wdata_i;
    logic        stall_o;
    logic        icpt_valid_o;
    logic        icpt_ready_i;
    logic [71:0] icpt_word_o;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   done  = 1'b0;

    logic        m_valid;
    logic [71:0] m_word;

    always #2.5 clk = ~clk;

    cfg_intercept_chan dut_i (
        .clk            (clk),
        .rst            (rst),
        .req_strobe_i   (req_strobe_i),
        .req_poison_i   (req_poison_i),
        .req_byte_en_i  (req_byte_en_i),
        .req_pf_i       (req_pf_i),
        .req_vf_i       (req_vf_i),
        .req_vf_ok_i    (req_vf_ok_i),
        .req_is_write_i (req_is_write_i),
        .req_dw_addr_i  (req_dw_addr_i),
        .req_wdata_i    (req_wdata_i),
        .stall_o        (stall_o),
        .icpt_valid_o   (icpt_valid_o),
        .icpt_ready_i   (icpt_ready_i),
        .icpt_word_o    (icpt_word_o)
    );

    // Expected word built from the field layout of R2 to R5
    function automatic logic [71:0] exp_word(
        logic p, logic [3:0] be, logic [2:0] pf, logic [10:0] vf,
        logic vok, logic wr, logic [9:0] a, logic [31:0] d);
        logic [71:0] w;
        w = '0;
        w[0]     = p;
        w[4:1]   = be;
        w[12:10] = pf;
        w[23:13] = vf;
        w[24]    = vok;
        w[25]    = wr;
        w[35:26] = a;
        if (wr) begin
            w[43:36] = d[7:0];
            w[51:44] = d[15:8];
            w[59:52] = d[23:16];
            w[67:60] = d[31:24];
        end
        return w;
    endfunction

    task automatic cmp(string tag, logic [71:0] act, logic [71:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        cmp("R6 R7 valid", {71'd0, icpt_valid_o}, {71'd0, m_valid});
        cmp("R9 stall", {71'd0, stall_o}, {71'd0, m_valid});
        cmp("R2 low fields", {59'd0, icpt_word_o[12:0]}, {59'd0, m_word[12:0]});
        cmp("R3 vf/addr/rsv", {45'd0, icpt_word_o[71:68], icpt_word_o[35:13]},
                              {45'd0, m_word[71:68], m_word[35:13]});
        if (m_word[25])
            cmp("R4 write payload", {29'd0, icpt_word_o[67:25]}, {29'd0, m_word[67:25]});
        else
            cmp("R5 read payload", {29'd0, icpt_word_o[67:25]}, {29'd0, m_word[67:25]});
    endtask

    // One cycle: inputs already set after the last edge; model advances at the edge
    task automatic step();
        logic [71:0] w;
        w = exp_word(req_poison_i, req_byte_en_i, req_pf_i, req_vf_i,
                     req_vf_ok_i, req_is_write_i, req_dw_addr_i, req_wdata_i);
        @(posedge clk);
        if (rst) begin
            m_valid = 1'b0;
            m_word  = '0;
        end else if (!m_valid && req_strobe_i) begin
            m_valid = 1'b1;
            m_word  = w;
        end else if (m_valid && icpt_ready_i) begin
            m_valid = 1'b0;
        end
        #1;
        compare_all();
    endtask

    task automatic set_req(logic s, logic p, logic [3:0] be, logic [2:0] pf,
                           logic [10:0] vf, logic vok, logic wr,
                           logic [9:0] a, logic [31:0] d, logic rdy);
        req_strobe_i   = s;
        req_poison_i   = p;
        req_byte_en_i  = be;
        req_pf_i       = pf;
        req_vf_i       = vf;
        req_vf_ok_i    = vok;
        req_is_write_i = wr;
        req_dw_addr_i  = a;
        req_wdata_i    = d;
        icpt_ready_i   = rdy;
    endtask

    task automatic idle_cycle(logic rdy);
        set_req(1'b0, $urandom, $urandom, $urandom, $urandom, $urandom, $urandom,
                $urandom, $urandom, rdy);
        step();
    endtask

    initial begin : watchdog
        #500000;
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : stim
        void'($urandom(32'h5eed_c0de));
        m_valid = 1'b0;
        m_word  = '0;
        rst = 1'b1;
        // R1: reset with a strobe present must still leave everything cleared
        set_req(1'b1, 1'b1, 4'hf, 3'h7, 11'h7ff, 1'b1, 1'b1, 10'h3ff, 32'hffff_ffff, 1'b1);
        repeat (3) step();
        rst = 1'b0;

        // R10: ready while idle has no effect
        idle_cycle(1'b1);
        idle_cycle(1'b1);

        // R4 R6: write to PF1, bytes 0 and 1, address 0x80; application not ready
        set_req(1'b1, 1'b0, 4'b0011, 3'd1, 11'd0, 1'b0, 1'b1, 10'h080, 32'hA1B2_C3D4, 1'b0);
        step();
        // R8 R9: strobe while stalled must be ignored
        set_req(1'b1, 1'b1, 4'hf, 3'd5, 11'd26, 1'b1, 1'b0, 10'h0FC, 32'h1111_2222, 1'b0);
        step();
        idle_cycle(1'b0);
        idle_cycle(1'b0);
        // R7: release
        idle_cycle(1'b1);
        // R9: nothing extra after release
        idle_cycle(1'b0);
        idle_cycle(1'b0);

        // R7: ready already high when the request appears -> one-cycle valid
        set_req(1'b1, 1'b1, 4'hf, 3'd5, 11'd26, 1'b1, 1'b1, 10'h0FC, 32'hDEAD_BEEF, 1'b1);
        step();
        idle_cycle(1'b1);
        idle_cycle(1'b1);

        // R5: read with non-zero data on the bus, payload must be zero
        set_req(1'b1, 1'b0, 4'h5, 3'd2, 11'h123, 1'b1, 1'b0, 10'h2AA, 32'hFFFF_FFFF, 1'b0);
        step();
        idle_cycle(1'b1);

        // R2 R3: all fields at their maximum
        set_req(1'b1, 1'b1, 4'hf, 3'h7, 11'h7ff, 1'b1, 1'b1, 10'h3ff, 32'hffff_ffff, 1'b0);
        step();
        idle_cycle(1'b1);

        // Constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            set_req(($urandom % 100) < 35, $urandom, $urandom, $urandom, $urandom,
                    $urandom, $urandom, $urandom, $urandom, ($urandom % 100) < 30);
            step();
        end

        // R1: reset in the middle of a hold
        set_req(1'b1, 1'b0, 4'h1, 3'd3, 11'd9, 1'b0, 1'b1, 10'h010, 32'h0102_0304, 1'b0);
        step();
        rst = 1'b1;
        idle_cycle(1'b0);
        rst = 1'b0;
        idle_cycle(1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule